// File: doc/BRIEF.md
# Descriptor-Ring Transmit DMA Engine

This block is a bus-master transmit engine. It works through a circular list of descriptors that the host builds in shared memory. Each descriptor is four 32-bit words in a 16-byte slot. The host fills a descriptor, sets its ownership bit and writes a poll strobe. The engine then reads the descriptor, fetches the buffer it names one word at a time, and streams the bytes out on a byte-wide valid/ready port with frame-start and frame-end markers. When the buffer is done, the engine writes a status word back with the ownership bit cleared, which returns the descriptor to the host.

After each descriptor the engine moves to the next 16-byte slot. If the descriptor carries the end-of-ring bit, it goes back to the base address instead. When it meets a descriptor it does not own, it stops and waits for the next poll. The operating enable is checked between descriptors, so a descriptor that has started always completes. All memory traffic goes through one word-wide request/acknowledge port.

Top module: `txring_dma`

## Requirements
- R1: After reset the engine is suspended, `mem_req` is low and `tx_valid` is low.
- R2: A fetch starts only on a `poll_kick` pulse while `tx_enable` is high. A poll while `tx_enable` is low is ignored: no memory request is made and the engine stays suspended.
- R3: Slot k lies at base + 16·k. Word 0 is at +0, word 1 at +4 and word 2 (the buffer address) at +8. Word 3 is never read. Frames go out in slot order.
- R4: If word 0 bit 31 (ownership) reads 0, the engine suspends and makes no further request until the next poll.
- R5: Word 1 bits 10:0 give the byte count N. Exactly N bytes are emitted, and none when N is 0. They are read from consecutive words starting at word 2 with its two low bits cleared, least significant byte first.
- R6: `tx_first` is high on the first byte only if word 1 bit 29 is set. `tx_last` is high on the final byte only if word 1 bit 30 is set.
- R7: After the last byte, word 0 is overwritten with bit 31 = 0, bit 15 = error summary and all other bits 0.
- R8: An error response (`mem_err` with `mem_ack`) on any buffer word read sets bit 15 in the written-back word 0.
- R9: Word 1 bit 25 (end of ring) sends the next fetch to slot 0. Otherwise the next fetch goes to the following slot.
- R10: A descriptor with word 1 bit 24 set raises `chain_unsup` for exactly one cycle. The descriptor is then processed as an ordinary ring entry.
- R11: If `tx_enable` is low when a descriptor's write-back completes, the engine suspends and leaves later descriptors untouched.
- R12: A `base_wr` pulse while suspended loads `base_in` and sets the slot index to 0.
- R13: `mem_req` stays high, with `mem_addr` and `mem_we` stable, until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Operating enable, checked at each descriptor boundary |
| poll_kick | input | 1 | Poll strobe that wakes a suspended engine |
| base_wr | input | 1 | Load strobe for the ring base |
| base_in | input | ADDR_W | Ring base address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_first | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| chain_unsup | output | 1 | One-cycle flag for a chained descriptor |
| suspended | output | 1 | Engine idle, waiting for a poll |

## Verification
The single-descriptor sweep covers every byte count from 0 to 9 under three downstream ready patterns. It therefore exercises partial last words, the zero-length path and back-pressure against word refills, and one pattern gives an unaligned buffer pointer. A four-slot ring with lengths 1, 4, 5 and 7 shows slot order, the wrap to slot 0 and suspension on a host-owned descriptor. Separate runs cover an error on a buffer word, cleared first/last flags, the chain flag, an enable drop mid-frame, a disabled poll and a base reload. Together they separate status write-back, marker gating and the index rewind.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int WORD_W  = 32;
    localparam int WORD_B  = WORD_W / 8;
    localparam int LANE_W  = $clog2(WORD_B);
    localparam int LEN_W   = 11;
    localparam int SLOT_SH = 4;

    localparam int BIT_OWN   = 31;
    localparam int BIT_LAST  = 30;
    localparam int BIT_FIRST = 29;
    localparam int BIT_EOR   = 25;
    localparam int BIT_CHAIN = 24;
    localparam int BIT_ERR   = 15;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_W0   = 3'd1,
        S_W1   = 3'd2,
        S_W2   = 3'd3,
        S_BUF  = 3'd4,
        S_STR  = 3'd5,
        S_WB   = 3'd6,
        S_ADV  = 3'd7
    } txr_state_e;
endpackage

// File: rtl/txr_slot_addr.sv
module txr_slot_addr #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        word_sel,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        addr = base + ADDR_W'({idx, 4'b0000}) + ADDR_W'({word_sel, 2'b00});
    end
endmodule

// File: rtl/txr_byte_pick.sv
module txr_byte_pick #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [WORD_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    output logic [7:0]        data
);
    always_comb begin
        data = word[{lane, 3'b000} +: 8];
    end
endmodule

// File: rtl/txring_dma.sv
module txring_dma
    import txr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_enable,
    input  logic              poll_kick,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_first,
    output logic              tx_last,
    output logic              chain_unsup,
    output logic              suspended
);
    typedef struct packed {
        txr_state_e         state;
        logic [ADDR_W-1:0]  base;
        logic [IDX_W-1:0]   idx;
        logic [LEN_W-1:0]   len;
        logic [ADDR_W-1:0]  bufp;
        logic [LANE_W-1:0]  lane;
        logic [WORD_W-1:0]  word;
        logic               fs;
        logic               ls;
        logic               eor;
        logic               err;
        logic               first_pend;
    } regs_t;

    regs_t r_q, r_d;

    logic [1:0]        word_sel;
    logic [ADDR_W-1:0] slot_addr;
    logic [7:0]        lane_byte;

    txr_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_slot (
        .base     (r_q.base),
        .idx      (r_q.idx),
        .word_sel (word_sel),
        .addr     (slot_addr)
    );

    txr_byte_pick #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_pick (
        .word (r_q.word),
        .lane (r_q.lane),
        .data (lane_byte)
    );

    always_comb begin
        unique case (r_q.state)
            S_W1:    word_sel = 2'd1;
            S_W2:    word_sel = 2'd2;
            default: word_sel = 2'd0;
        endcase
    end

    always_comb begin
        r_d         = r_q;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = slot_addr;
        mem_wdata   = '0;
        tx_valid    = 1'b0;
        tx_data     = lane_byte;
        tx_first    = 1'b0;
        tx_last     = 1'b0;
        chain_unsup = 1'b0;

        unique case (r_q.state)
            S_IDLE: begin
                if (base_wr) begin
                    r_d.base = base_in;
                    r_d.idx  = '0;
                end
                if (poll_kick && tx_enable) begin
                    r_d.state = S_W0;
                end
            end
            S_W0: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.err   = 1'b0;
                    r_d.state = mem_rdata[BIT_OWN] ? S_W1 : S_IDLE;
                end
            end
            S_W1: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.len     = mem_rdata[LEN_W-1:0];
                    r_d.fs      = mem_rdata[BIT_FIRST];
                    r_d.ls      = mem_rdata[BIT_LAST];
                    r_d.eor     = mem_rdata[BIT_EOR];
                    chain_unsup = mem_rdata[BIT_CHAIN];
                    r_d.state   = S_W2;
                end
            end
            S_W2: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.bufp       = {mem_rdata[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
                    r_d.lane       = '0;
                    r_d.first_pend = 1'b1;
                    r_d.state      = (r_q.len == '0) ? S_WB : S_BUF;
                end
            end
            S_BUF: begin
                mem_req  = 1'b1;
                mem_addr = r_q.bufp;
                if (mem_ack) begin
                    r_d.word  = mem_rdata;
                    r_d.err   = r_q.err | mem_err;
                    r_d.state = S_STR;
                end
            end
            S_STR: begin
                tx_valid = 1'b1;
                tx_first = r_q.fs && r_q.first_pend;
                tx_last  = r_q.ls && (r_q.len == LEN_W'(1));
                if (tx_ready) begin
                    r_d.first_pend = 1'b0;
                    r_d.len        = r_q.len - LEN_W'(1);
                    r_d.lane       = r_q.lane + LANE_W'(1);
                    if (r_q.len == LEN_W'(1)) begin
                        r_d.state = S_WB;
                    end else if (r_q.lane == LANE_W'(WORD_B - 1)) begin
                        r_d.bufp  = r_q.bufp + ADDR_W'(WORD_B);
                        r_d.state = S_BUF;
                    end
                end
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = 32'(r_q.err) << BIT_ERR;
                if (mem_ack) begin
                    r_d.state = S_ADV;
                end
            end
            S_ADV: begin
                r_d.idx   = r_q.eor ? '0 : r_q.idx + IDX_W'(1);
                r_d.state = tx_enable ? S_W0 : S_IDLE;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    assign suspended = (r_q.state == S_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_enable,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              wb_own,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_first,
    input logic              tx_last,
    input logic              chain_unsup,
    input logic              suspended
);
    // R13: an open request holds its address and direction
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R5: a stalled byte stays on the port unchanged
    a_r5_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)
                                 && $stable(tx_first) && $stable(tx_last));

    // R4: a suspended engine issues nothing
    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> !mem_req && !tx_valid);

    // R7: write-back always releases ownership
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !wb_own);

    // R10: chain flag lasts one cycle
    a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chain_unsup |=> !chain_unsup);

    // R2: no wake-up while disabled
    a_r2_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        suspended && !tx_enable |=> suspended);

    // R6: the start marker appears once per frame
    a_r6_single_first: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_first |=> !(tx_valid && tx_first));
endmodule

bind txring_dma txring_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_enable   (tx_enable),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .wb_own      (mem_wdata[31]),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .tx_data     (tx_data),
    .tx_first    (tx_first),
    .tx_last     (tx_last),
    .chain_unsup (chain_unsup),
    .suspended   (suspended)
);

// File: tb/txring_dma_tb_top.sv
module txring_dma_tb_top;
    localparam int AW = 32;
    localparam logic [31:0] B0 = 32'h100;
    localparam logic [31:0] B1 = 32'h200;
    localparam logic [31:0] JUNK0 = 32'h0000_1234;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_enable = 1'b0, poll_kick = 1'b0, base_wr = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic tx_valid, tx_ready = 1'b1, tx_first, tx_last, chain_unsup, suspended;
    logic [7:0] tx_data;

    always #5 clk = ~clk;

    txring_dma #(.ADDR_W(AW), .IDX_W(6)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .poll_kick(poll_kick),
        .base_wr(base_wr), .base_in(base_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last),
        .chain_unsup(chain_unsup), .suspended(suspended)
    );

    logic [31:0] mem [0:1023];
    int tests = 0, fails = 0;
    int req_count = 0, w3_reads = 0, watch_hits = 0, hs_bad = 0, chain_cnt = 0;
    logic [31:0] watch_addr = '1, err_addr = '1;
    logic pend = 1'b0, pwe = 1'b0;
    logic [31:0] paddr = '0;
    int ready_mode = 0, cyc = 0;
    logic [7:0] rx_data [0:255];
    logic rx_f [0:255];
    logic rx_l [0:255];
    int rx_cnt = 0;

    // memory model: one wait cycle, then acknowledge
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (mem_req) begin
            if (!pend) begin
                pend = 1'b1; paddr = mem_addr; pwe = mem_we;
            end else begin
                if (mem_addr != paddr || mem_we != pwe) hs_bad++;
                pend = 1'b0;
                req_count++;
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else begin
                    mem_rdata = mem[mem_addr[11:2]];
                    if (mem_addr == watch_addr) watch_hits++;
                    if (mem_addr < 32'h400 && mem_addr[3:0] == 4'hC) w3_reads++;
                end
                mem_err = (!mem_we && mem_addr == err_addr);
                mem_ack = 1'b1;
            end
        end
    end

    // downstream sink and flag monitor
    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            1: tx_ready = cyc[0];
            2: tx_ready = (cyc % 3 == 0);
            default: tx_ready = 1'b1;
        endcase
        #1;
        if (tx_valid && tx_ready && rx_cnt < 256) begin
            rx_data[rx_cnt] = tx_data;
            rx_f[rx_cnt] = tx_first;
            rx_l[rx_cnt] = tx_last;
            rx_cnt++;
        end
        if (chain_unsup) chain_cnt++;
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 7 + i * 13 + 5) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_buf(input logic [31:0] a, input int len, input int seed);
        for (int i = 0; i < len; i++)
            mem[a[11:2] + 10'(i / 4)][8 * (i % 4) +: 8] = pat(seed, i);
    endtask

    task automatic put_desc(input logic [31:0] base, input int slot, input bit own, input int len,
                            input bit fs, input bit ls, input bit eor, input bit chain,
                            input logic [31:0] bufa);
        int w;
        w = int'(base >> 2) + slot * 4;
        mem[w]     = (32'(own) << 31) | JUNK0;
        mem[w + 1] = (32'(ls) << 30) | (32'(fs) << 29) | (32'(eor) << 25) | (32'(chain) << 24) | 32'(len);
        mem[w + 2] = bufa;
        mem[w + 3] = 32'hDEAD_0000;
    endtask

    task automatic kick_and_wait();
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (suspended) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    // compares one frame in the receive log
    task automatic check_frame(input int off, input int len, input int seed, input bit fs, input bit ls);
        int bad_d, bad_f, bad_l;
        bad_d = 0; bad_f = 0; bad_l = 0;
        for (int i = 0; i < len; i++) begin
            if (rx_data[off + i] !== pat(seed, i)) bad_d++;
            if (rx_f[off + i] !== (fs && i == 0)) bad_f++;
            if (rx_l[off + i] !== (ls && i == len - 1)) bad_l++;
        end
        chk(bad_d == 0, "R5 byte content/order", bad_d, 0);
        chk(bad_f == 0, "R6 first marker", bad_f, 0);
        chk(bad_l == 0, "R6 last marker", bad_l, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lens [4];
        int off, rbase;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        lens = '{1, 4, 5, 7};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(suspended && !mem_req && !tx_valid, "R1 reset idle",
            {29'd0, suspended, mem_req, tx_valid}, 32'd4);

        @(negedge clk); base_wr = 1'b1; base_in = B0;
        @(negedge clk); base_wr = 1'b0;

        // ring of four owned slots, last one wraps
        for (int k = 0; k < 4; k++) begin
            put_desc(B0, k, 1'b1, lens[k], 1'b1, 1'b1, k == 3, 1'b0, 32'h400 + 32'(k * 32));
            put_buf(32'h400 + 32'(k * 32), lens[k], k * 16 + 1);
        end

        // R2: poll while disabled
        rbase = req_count;
        kick_and_wait();
        chk(req_count == rbase && suspended, "R2 poll ignored while disabled", req_count - rbase, 0);

        // R3 R9 R4: four frames, wrap, suspend on host-owned slot 0
        tx_enable = 1'b1; rx_cnt = 0; watch_addr = B0; watch_hits = 0;
        kick_and_wait();
        chk(rx_cnt == 17, "R5 ring byte total", rx_cnt, 17);
        off = 0;
        for (int k = 0; k < 4; k++) begin
            check_frame(off, lens[k], k * 16 + 1, 1'b1, 1'b1); // R3 slot order
            chk(mem[B0[11:2] + 10'(k * 4)] == 32'h0, "R7 status write-back",
                mem[B0[11:2] + 10'(k * 4)], 0);
            off += lens[k];
        end
        chk(watch_hits == 2, "R9 wrap back to slot 0", watch_hits, 2);
        rbase = req_count;
        repeat (20) @(negedge clk);
        chk(suspended && req_count == rbase, "R4 suspended on unowned slot", req_count - rbase, 0);

        // near-exhaustive sweep: length x ready pattern (mode 2 uses an unaligned pointer)
        for (int len = 0; len < 10; len++) begin
            for (int mode = 0; mode < 3; mode++) begin
                ready_mode = mode; rx_cnt = 0;
                put_desc(B0, 0, 1'b1, len, 1'b1, 1'b1, 1'b1, 1'b0, 32'h500 | 32'(mode == 2 ? 3 : 0));
                put_buf(32'h500, len, len * 5 + mode);
                kick_and_wait();
                chk(rx_cnt == len, "R5 byte count", rx_cnt, len);
                check_frame(0, len, len * 5 + mode, 1'b1, 1'b1);
                chk(mem[B0[11:2]] == 32'h0, "R7 sweep write-back", mem[B0[11:2]], 0);
            end
        end
        ready_mode = 0;

        // R8: error on second buffer word
        rx_cnt = 0; err_addr = 32'h504;
        put_desc(B0, 0, 1'b1, 6, 1'b1, 1'b1, 1'b1, 1'b0, 32'h500);
        put_buf(32'h500, 6, 77);
        kick_and_wait();
        err_addr = '1;
        chk(mem[B0[11:2]] == 32'h0000_8000, "R8 error summary set", mem[B0[11:2]], 32'h8000);
        chk(rx_cnt == 6, "R8 frame still streamed", rx_cnt, 6);

        // R6: markers withheld when bits clear
        rx_cnt = 0;
        put_desc(B0, 0, 1'b1, 3, 1'b0, 1'b0, 1'b1, 1'b0, 32'h500);
        put_buf(32'h500, 3, 12);
        kick_and_wait();
        chk(rx_cnt == 3, "R6 unmarked frame count", rx_cnt, 3);
        check_frame(0, 3, 12, 1'b0, 1'b0);

        // R10: chained descriptor flagged, processed as ring entry
        rx_cnt = 0; chain_cnt = 0;
        put_desc(B0, 0, 1'b1, 2, 1'b1, 1'b1, 1'b1, 1'b1, 32'h500);
        put_buf(32'h500, 2, 33);
        kick_and_wait();
        chk(chain_cnt == 1, "R10 chain flag pulse", chain_cnt, 1);
        chk(rx_cnt == 2 && mem[B0[11:2]] == 0, "R10 chained entry processed", rx_cnt, 2);
        chk(w3_reads == 0, "R3 word 3 never read", w3_reads, 0);

        // R11: enable dropped during slot 0
        rx_cnt = 0;
        put_desc(B0, 0, 1'b1, 8, 1'b1, 1'b1, 1'b0, 1'b0, 32'h500);
        put_desc(B0, 1, 1'b1, 8, 1'b1, 1'b1, 1'b1, 1'b0, 32'h540);
        put_buf(32'h500, 8, 50);
        put_buf(32'h540, 8, 51);
        @(negedge clk); poll_kick = 1'b1;
        @(negedge clk); poll_kick = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (rx_cnt > 0) break;
            @(negedge clk);
        end
        tx_enable = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (suspended) break;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        chk(rx_cnt == 8, "R11 current frame completes", rx_cnt, 8);
        chk(mem[B0[11:2]] == 0, "R11 slot 0 released", mem[B0[11:2]], 0);
        chk(mem[B0[11:2] + 10'd4] == (32'h8000_0000 | JUNK0), "R11 slot 1 untouched",
            mem[B0[11:2] + 10'd4], 32'h8000_0000 | JUNK0);

        // R2 again: disabled poll leaves slot 1 owned
        rbase = req_count;
        kick_and_wait();
        chk(req_count == rbase, "R2 no request while disabled", req_count - rbase, 0);

        // R12: base reload rewinds index to slot 0 of new ring
        @(negedge clk); base_wr = 1'b1; base_in = B1;
        @(negedge clk); base_wr = 1'b0;
        put_desc(B1, 0, 1'b1, 2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h700);
        put_buf(32'h700, 2, 99);
        rx_cnt = 0; tx_enable = 1'b1;
        kick_and_wait();
        chk(rx_cnt == 2, "R12 frame from new base", rx_cnt, 2);
        check_frame(0, 2, 99, 1'b1, 1'b1);
        chk(mem[B1[11:2]] == 0, "R12 new slot 0 released", mem[B1[11:2]], 0);
        chk(mem[B0[11:2] + 10'd4] == (32'h8000_0000 | JUNK0), "R12 old ring untouched",
            mem[B0[11:2] + 10'd4], 32'h8000_0000 | JUNK0);

        chk(hs_bad == 0, "R13 request held until ack", hs_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule